// File: doc/BRIEF.md
# Battery-Backed SRAM Chip-Enable Decoder

This block sits between a core's internal byte address space and external static RAM on a byte-wide bus that does not multiplex address and data. It turns a 17-bit address and separate read and write requests into a 15-bit device address, four active-low select pins and an active-low write strobe. The select pins and the write strobe are registered.

The block has two layouts. In split mode, each of the four select pins enables its own 32K device, and the top two address bits choose which pin goes low. In single-device mode, one 128K part is fitted. Pin 0 is then its enable, and pins 1 and 2 carry address bits 16 and 15. A boundary input divides the space into a program region and a data region. The program region begins at address zero, and the write strobe never fires inside it.

A main-supply-fail input is synchronised inside the block. While it is high, every select pin and the write strobe are held inactive, so that a memory running from its backup cell is not disturbed.

Top module: `sram_ce_decoder`

## Requirements
- R1: After reset is asserted, `cs_n_o` is 4'b1111, `we_n_o` is 1 and `mem_addr_o` is 0.
- R2: Split mode (`single_dev_i`=0). At the first clock edge at which a request is seen, `mem_addr_o` takes `addr_i[14:0]`. At the same edge, `cs_n_o[k]` goes low, where k=`addr_i[16:15]`, and the other three pins stay high.
- R3: Single-device mode (`single_dev_i`=1). During a request, `cs_n_o[0]` is low, `cs_n_o[1]` equals `addr_i[16]`, `cs_n_o[2]` equals `addr_i[15]` and `cs_n_o[3]` is high.
- R4: A 32K block whose index `addr_i[16:15]` is below `prog_bound_i` is program space. A write there never drives `we_n_o` low, but the select pin is still asserted. A bound of 0 makes all four blocks data. A bound of 4 or more makes all four blocks program.
- R5: For a write to data space, `we_n_o` goes low one edge after the select pin goes low. It stays low while `wr_req_i` is held, and it goes high at the edge at which `wr_req_i` is seen low.
- R6: After a write that drove `we_n_o` low, the select pin stays asserted for one more cycle after `we_n_o` rises, and then it releases.
- R7: A read never drives `we_n_o` low. The select pin releases at the first edge at which `rd_req_i` is seen low.
- R8: With no request and no pending write hold, `cs_n_o` is 4'b1111 in split mode. In single-device mode, `cs_n_o[0]` is 1.
- R9: By the third clock edge after `pwr_fail_i` rises, and for as long as it stays high, `cs_n_o` is 4'b1111 and `we_n_o` is 1, whatever the requests are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 17 | Internal byte address |
| rd_req_i | input | 1 | Read request |
| wr_req_i | input | 1 | Write request, held for the length of the access |
| single_dev_i | input | 1 | 1: one 128K device; 0: four 32K devices |
| prog_bound_i | input | 3 | Number of 32K blocks, counted from zero, that hold program |
| pwr_fail_i | input | 1 | Main supply below backup cell, asynchronous |
| mem_addr_o | output | 15 | Device address |
| cs_n_o | output | 4 | Select pins, active low; pins 1 and 2 carry address bits 16 and 15 in single-device mode |
| we_n_o | output | 1 | Write strobe, active low |

## Verification
The hardest case to reach is a supply failure that arrives in the middle of a write, once the strobe is already low. The failure has to cut the strobe and the select pin together, with no hold cycle. To reach it, the stimulus holds a data-space write until the strobe is observed low. It then raises `pwr_fail_i` while the request is still present, and checks after the two synchroniser stages and the output register. Program-space writes are driven in both modes, with the boundary at 0 and at 4. This shows that the select pin still fires while the strobe stays quiet.

// File: rtl/sram_ce_pkg.sv
package sram_ce_pkg;
  localparam int unsigned ADDR_W = 17;
  localparam int unsigned BUS_W  = 15;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/sram_ce_sync.sv
module sram_ce_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sram_ce_region.sv
module sram_ce_region #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned BUS_W  = 15,
  localparam int unsigned BLK_W = ADDR_W - BUS_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BLK_W:0]    prog_bound_i,
  output logic [BLK_W-1:0]  blk_o,
  output logic              prog_o
);
  assign blk_o  = addr_i[ADDR_W-1:BUS_W];
  // blocks below the boundary hold program
  assign prog_o = ({1'b0, blk_o} < prog_bound_i);
endmodule

// File: rtl/sram_ce_strobe.sv
module sram_ce_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_req_i,
  input  logic wr_req_i,
  input  logic prog_i,
  input  logic pf_i,
  output logic load_o,
  output logic cs_act_o,
  output logic we_act_o,
  output logic pf_o
);
  logic wr_act_q, we_q, cs_q, pf_q;
  logic any_req, hold_d, cs_d, we_d;

  assign any_req = (rd_req_i | wr_req_i) & ~pf_i;
  // keep the select one cycle past the strobe's rising edge
  assign hold_d  = we_q & ~wr_req_i & ~pf_i;
  assign cs_d    = any_req | hold_d;
  assign we_d    = wr_req_i & wr_act_q & ~prog_i & ~pf_i;
  assign load_o  = any_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      we_q     <= 1'b0;
      cs_q     <= 1'b0;
      pf_q     <= 1'b0;
    end else begin
      wr_act_q <= wr_req_i & ~pf_i;
      we_q     <= we_d;
      cs_q     <= cs_d;
      pf_q     <= pf_i;
    end
  end

  assign cs_act_o = cs_q;
  assign we_act_o = we_q;
  assign pf_o     = pf_q;
endmodule

// File: rtl/sram_ce_decoder.sv
module sram_ce_decoder
  import sram_ce_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BUS_W,
  localparam int unsigned BLK_W = AW - BW,
  localparam int unsigned NCE   = 1 << BLK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_req_i,
  input  logic          wr_req_i,
  input  logic          single_dev_i,
  input  logic [BLK_W:0] prog_bound_i,
  input  logic          pwr_fail_i,
  output logic [BW-1:0] mem_addr_o,
  output logic [NCE-1:0] cs_n_o,
  output logic          we_n_o
);
  logic             pf_s, pf_q, load, cs_act_q, we_act, prog;
  logic [BLK_W-1:0] blk, blk_q;
  logic [BW-1:0]    addr_q;

  sram_ce_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pwr_fail_i), .q_o(pf_s)
  );

  sram_ce_region #(.ADDR_W(AW), .BUS_W(BW)) u_region (
    .addr_i(addr_i), .prog_bound_i(prog_bound_i), .blk_o(blk), .prog_o(prog)
  );

  sram_ce_strobe u_strobe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_req_i(rd_req_i),
    .wr_req_i(wr_req_i),
    .prog_i  (prog),
    .pf_i    (pf_s),
    .load_o  (load),
    .cs_act_o(cs_act_q),
    .we_act_o(we_act),
    .pf_o    (pf_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      blk_q  <= '0;
    end else if (load) begin
      addr_q <= addr_i[BW-1:0];
      blk_q  <= blk;
    end
  end

  assign mem_addr_o = addr_q;
  assign we_n_o     = ~we_act;

  for (genvar g = 0; g < NCE; g++) begin : g_pin
    logic split_v, single_v;
    assign split_v = ~(cs_act_q && (blk_q == BLK_W'(g)));
    if (g == 0) begin : g_en
      assign single_v = ~cs_act_q;
    end else if (g <= BLK_W) begin : g_abit
      // pin g carries address bit (BW + BLK_W - g)
      assign single_v = blk_q[BLK_W-g];
    end else begin : g_off
      assign single_v = 1'b1;
    end
    assign cs_n_o[g] = pf_q | (single_dev_i ? single_v : split_v);
  end
endmodule

// File: rtl/sram_ce_decoder_chk.sv
module sram_ce_decoder_chk #(
  parameter int unsigned NCE = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           rd_req_i,
  input logic           wr_req_i,
  input logic           single_dev_i,
  input logic [NCE-1:0] cs_n_o,
  input logic           we_n_o,
  input logic           pf_s,
  input logic           cs_act_q
);
  // R5
  we_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> cs_act_q);
  // R5
  we_after_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_n_o) |-> $past(cs_act_q));
  // R6
  we_rise_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) && !pf_s && !$past(pf_s) |-> cs_act_q);
  // R7
  we_from_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> $past(wr_req_i));
  // R8
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_req_i && !wr_req_i && we_n_o) |=> !cs_act_q);
  // R9
  pf_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_s |=> (cs_n_o == '1) && we_n_o);
  // R2
  split_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act_q && !single_dev_i) |-> $countones(~cs_n_o) == 1);
endmodule

bind sram_ce_decoder sram_ce_decoder_chk #(.NCE(NCE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_req_i(rd_req_i), .wr_req_i(wr_req_i),
  .single_dev_i(single_dev_i), .cs_n_o(cs_n_o), .we_n_o(we_n_o),
  .pf_s(pf_s), .cs_act_q(cs_act_q)
);

// File: tb/sram_ce_decoder_bench.sv
`timescale 1ns/1ps
module sram_ce_decoder_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [16:0] addr_i = '0;
  logic        rd_req_i = 1'b0, wr_req_i = 1'b0, single_dev_i = 1'b0, pwr_fail_i = 1'b0;
  logic [2:0]  prog_bound_i = '0;
  logic [14:0] mem_addr_o;
  logic [3:0]  cs_n_o;
  logic        we_n_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  sram_ce_decoder u_sram_ce_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_req_i(rd_req_i),
    .wr_req_i(wr_req_i), .single_dev_i(single_dev_i), .prog_bound_i(prog_bound_i),
    .pwr_fail_i(pwr_fail_i), .mem_addr_o(mem_addr_o), .cs_n_o(cs_n_o), .we_n_o(we_n_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] split_sel(input logic [16:0] a);
    logic [3:0] v = 4'hF;
    v[a[16:15]] = 1'b0;
    return v;
  endfunction

  task automatic t_reset();
    #1;
    chk("R1 cs", 32'(cs_n_o), 32'hF);
    chk("R1 we", 32'(we_n_o), 32'h1);
    chk("R1 addr", 32'(mem_addr_o), 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 idle", 32'(cs_n_o), 32'hF);
  endtask

  task automatic t_split_read();
    single_dev_i = 1'b0;
    for (int b = 0; b < 4; b++) begin
      addr_i = {b[1:0], 15'h1234 + 15'(b)}; rd_req_i = 1'b1;
      @(negedge clk_i);
      chk("R2 cs", 32'(cs_n_o), 32'(split_sel(addr_i)));
      chk("R2 addr", 32'(mem_addr_o), 32'(addr_i[14:0]));
      chk("R7 we", 32'(we_n_o), 32'h1);
      rd_req_i = 1'b0;
      @(negedge clk_i);
      chk("R7 release", 32'(cs_n_o), 32'hF);
    end
  endtask

  task automatic t_single_read();
    logic [16:0] al [3] = '{17'h1_8005, 17'h0_8003, 17'h1_0000};
    logic [3:0]  ex [3] = '{4'b1110, 4'b1100, 4'b1010};
    single_dev_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      addr_i = al[i]; rd_req_i = 1'b1;
      @(negedge clk_i);
      chk("R3 pins", 32'(cs_n_o), 32'(ex[i]));
      chk("R3 addr", 32'(mem_addr_o), 32'(al[i][14:0]));
      rd_req_i = 1'b0;
      @(negedge clk_i);
      chk("R8 single idle", 32'(cs_n_o[0]), 32'h1);
    end
    single_dev_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_write(input logic [16:0] a, input logic [2:0] bound, input logic dev,
                         input logic exp_we);
    logic [3:0] sel;
    single_dev_i = dev; prog_bound_i = bound;
    sel = dev ? {1'b1, a[15], a[16], 1'b0} : split_sel(a);
    addr_i = a; wr_req_i = 1'b1;
    @(negedge clk_i);
    chk("R5 cs first", 32'(cs_n_o), 32'(sel));
    chk("R5 we delayed", 32'(we_n_o), 32'h1);
    @(negedge clk_i);
    chk(exp_we ? "R5 we low" : "R4 we blocked", 32'(we_n_o), 32'(!exp_we));
    chk("R4 cs kept", 32'(cs_n_o), 32'(sel));
    wr_req_i = 1'b0;
    @(negedge clk_i);
    chk("R5 we high", 32'(we_n_o), 32'h1);
    if (exp_we) chk("R6 hold", 32'(cs_n_o), 32'(sel));
    else        chk("R6 no hold", 32'(cs_n_o[0]), 32'h1);
    @(negedge clk_i);
    chk("R6 release", 32'(cs_n_o[0]), 32'h1);
    single_dev_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_pwrfail();
    single_dev_i = 1'b0; prog_bound_i = 3'd0;
    addr_i = 17'h1_0042; wr_req_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    chk("R9 pre we", 32'(we_n_o), 32'h0);
    pwr_fail_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R9 cs off", 32'(cs_n_o), 32'hF);
    chk("R9 we off", 32'(we_n_o), 32'h1);
    rd_req_i = 1'b1; addr_i = 17'h0_0001;
    repeat (3) @(negedge clk_i);
    chk("R9 still off", 32'(cs_n_o), 32'hF);
    rd_req_i = 1'b0; wr_req_i = 1'b0; pwr_fail_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R8 after pf", 32'(cs_n_o), 32'hF);
  endtask

  initial begin
    t_reset();
    t_split_read();
    t_single_read();
    t_write(17'h1_2345, 3'd0, 1'b0, 1'b1);
    t_write(17'h0_0010, 3'd1, 1'b0, 1'b0);
    t_write(17'h0_9000, 3'd1, 1'b0, 1'b1);
    t_write(17'h1_F000, 3'd4, 1'b0, 1'b0);
    t_write(17'h1_8001, 3'd4, 1'b1, 1'b0);
    t_write(17'h1_0007, 3'd2, 1'b1, 1'b1);
    t_pwrfail();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule